// File: doc/BRIEF.md
# Bidirectional Mailbox Register Port

This block is a two-sided mailbox between an external master bus and an internal slave bus, both clocked by one clock. Each of the lower addresses names two separate byte registers. A master write fills the master-to-slave register. A master read at the same address returns the slave-to-master register. The slave side sees the same pairs the other way round. The top address on both sides is a shared status word.

Every data register carries a full flag. The writing side sets the flag and the reading side clears it, so either party can poll the status word to see which mailboxes are waiting. Register zero is the doorbell register in each direction. A slave store there raises the master interrupt line. A master store there raises a pending slave interrupt, which reaches the slave through an enable input. A master store to the status address keeps no data and only emits a one-cycle notification pulse to the slave.

Top module: `mbox_port`

## Requirements
- R1: After reset every data register is zero, every full flag is clear, the status word reads 0x00 from both sides, and `m_irq`, `s_irq` and `s_doorbell` are low.
- R2: A master write (`m_cs`=1, `m_wr`=1) to address 0..2 stores `m_wdata` in that master-to-slave register. A slave read at the same address returns it, and the register keeps its value until the master writes it again.
- R3: A master read at address 0..2 returns the slave-to-master register written by the slave, never the value the master wrote at that address.
- R4: Status word layout: bits 0..2 are the master-to-slave full flags for registers 0..2, bit 3 is the pending slave interrupt, bits 4..6 are the slave-to-master full flags, and bit 7 is the pending master interrupt. A write sets the flag of its register, and a read by the other side clears it on the following clock edge.
- R5: A slave write to register 0 sets `m_irq` (status bit 7) after the clock edge. A master read of register 0 clears it.
- R6: A master write to register 0 sets the pending slave interrupt (status bit 3). `s_irq` equals the pending bit ANDed with `s_irq_en`. A slave read of register 0 clears the pending bit.
- R7: Writes to registers 1 and 2 in either direction raise no interrupt.
- R8: A master write to address 3 changes no data register and no full flag. It drives `s_doorbell` high for exactly the one cycle after the write.
- R9: If a register is written and read by the other side in the same cycle, the write wins: the new data is stored, the full flag stays set, and for register 0 the pending interrupt stays set.
- R10: Reading the status word from either side changes no flag and no interrupt.
- R11: Master read and write strobes have no effect while `m_cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both buses |
| rst_n | input | 1 | Active-low synchronous reset |
| m_cs | input | 1 | Master chip select |
| m_wr | input | 1 | Master write strobe |
| m_rd | input | 1 | Master read strobe |
| m_addr | input | ADDR_W | Master register address |
| m_wdata | input | DATA_W | Master write data |
| m_rdata | output | DATA_W | Master read data |
| m_irq | output | 1 | Interrupt to the master |
| s_wr | input | 1 | Slave write strobe |
| s_rd | input | 1 | Slave read strobe |
| s_addr | input | ADDR_W | Slave register address |
| s_wdata | input | DATA_W | Slave write data |
| s_rdata | output | DATA_W | Slave read data |
| s_irq_en | input | 1 | Slave interrupt enable |
| s_irq | output | 1 | Interrupt to the slave |
| s_doorbell | output | 1 | One-cycle pulse on a master status write |

## Verification
The bench builds the block with its defaults: an 8-bit data path, two address bits (three mailboxes per direction plus status) and combinational read data. That lets it sample a read value in the same cycle as its strobe and see the flag change at the next edge. With these values every status bit is directly observable, and so are the same-cycle write/read collisions on register 0 and the doorbell pulse. The registered read-data variant is left to its own build.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
   // Status word bit positions for a mailbox with nreg data registers per side
   function automatic int fwd_full_pos(int i);
      return i;
   endfunction
   function automatic int slv_pend_pos(int nreg);
      return nreg;
   endfunction
   function automatic int rev_full_pos(int nreg, int i);
      return nreg + 1 + i;
   endfunction
   function automatic int mst_pend_pos(int nreg);
      return 2 * nreg + 1;
   endfunction
   function automatic int stat_bits(int nreg);
      return 2 * nreg + 2;
   endfunction
endpackage

// File: rtl/mbox_dir.sv
`timescale 1ns/1ps
module mbox_dir #(
   parameter int DATA_W = 8,
   parameter int NREG   = 3,
   parameter int IDX_W  = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic                          rd_en,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [NREG-1:0][DATA_W-1:0]   regs,
   output logic [NREG-1:0]               full
);
   for (genvar i = 0; i < NREG; i++) begin : g_slot
      logic hit_w, hit_r;
      assign hit_w = wr_en && (wr_idx == IDX_W'(i));
      assign hit_r = rd_en && (rd_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            regs[i] <= '0;
            full[i] <= 1'b0;
         end else if (hit_w) begin
            regs[i] <= wr_data;
            full[i] <= 1'b1;
         end else if (hit_r) begin
            full[i] <= 1'b0;
         end
      end

      // R4
      full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_idx == IDX_W'(i)) |=> full[i]);
      // R4
      full_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && rd_idx == IDX_W'(i) && !(wr_en && wr_idx == IDX_W'(i))) |=> !full[i]);
      // R2
      data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && wr_idx == IDX_W'(i)) |=> $stable(regs[i]));
   end
endmodule

// File: rtl/mbox_irq.sv
`timescale 1ns/1ps
module mbox_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pend
);
   always_ff @(posedge clk) begin
      if (!rst_n)   pend <= 1'b0;
      else if (set) pend <= 1'b1;
      else if (clr) pend <= 1'b0;
   end

   // R9
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> pend);
   // R5
   pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !pend);
endmodule

// File: rtl/mbox_rdmux.sv
`timescale 1ns/1ps
module mbox_rdmux #(
   parameter int DATA_W = 8,
   parameter int NREG   = 3,
   parameter int IDX_W  = 2,
   parameter bit RD_REG = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NREG-1:0][DATA_W-1:0] regs,
   input  logic [DATA_W-1:0]           status,
   input  logic [IDX_W-1:0]            idx,
   output logic [DATA_W-1:0]           rdata
);
   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = status;
      for (int i = 0; i < NREG; i++) begin
         if (idx == IDX_W'(i)) sel = regs[i];
      end
   end

   if (RD_REG) begin : g_flop
      always_ff @(posedge clk) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= sel;
      end
   end else begin : g_comb
      assign rdata = sel;
   end
endmodule

// File: rtl/mbox_port.sv
`timescale 1ns/1ps
module mbox_port #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_cs,
   input  logic              m_wr,
   input  logic              m_rd,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic [DATA_W-1:0] m_wdata,
   output logic [DATA_W-1:0] m_rdata,
   output logic              m_irq,
   input  logic              s_wr,
   input  logic              s_rd,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_wdata,
   output logic [DATA_W-1:0] s_rdata,
   input  logic              s_irq_en,
   output logic              s_irq,
   output logic              s_doorbell
);
   import mbox_pkg::*;

   localparam int NREG = (1 << ADDR_W) - 1;
   localparam logic [ADDR_W-1:0] STAT_IDX = ADDR_W'(NREG);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("mbox_port: ADDR_W must be at least 1");
   end
   if (DATA_W < stat_bits(NREG)) begin : g_bad_data
      $error("mbox_port: DATA_W too narrow for the status word");
   end

   logic m_wen, m_ren, s_wen, s_ren, m_stat_wr;
   assign m_wen     = m_cs && m_wr && (m_addr != STAT_IDX);
   assign m_ren     = m_cs && m_rd && (m_addr != STAT_IDX);
   assign s_wen     = s_wr && (s_addr != STAT_IDX);
   assign s_ren     = s_rd && (s_addr != STAT_IDX);
   assign m_stat_wr = m_cs && m_wr && (m_addr == STAT_IDX);

   logic [NREG-1:0][DATA_W-1:0] fwd_regs, rev_regs;
   logic [NREG-1:0]             fwd_full, rev_full;
   logic                        s_pend, m_pend;
   logic [DATA_W-1:0]           status;

   // master-to-slave direction
   mbox_dir #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(ADDR_W)) u_fwd (
      .clk(clk), .rst_n(rst_n),
      .wr_en(m_wen), .wr_idx(m_addr), .wr_data(m_wdata),
      .rd_en(s_ren), .rd_idx(s_addr),
      .regs(fwd_regs), .full(fwd_full));

   // slave-to-master direction
   mbox_dir #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(ADDR_W)) u_rev (
      .clk(clk), .rst_n(rst_n),
      .wr_en(s_wen), .wr_idx(s_addr), .wr_data(s_wdata),
      .rd_en(m_ren), .rd_idx(m_addr),
      .regs(rev_regs), .full(rev_full));

   mbox_irq u_slv_irq (
      .clk(clk), .rst_n(rst_n),
      .set(m_wen && m_addr == '0),
      .clr(s_ren && s_addr == '0),
      .pend(s_pend));

   mbox_irq u_mst_irq (
      .clk(clk), .rst_n(rst_n),
      .set(s_wen && s_addr == '0),
      .clr(m_ren && m_addr == '0),
      .pend(m_pend));

   always_comb begin
      status = '0;
      for (int i = 0; i < NREG; i++) begin
         status[fwd_full_pos(i)]       = fwd_full[i];
         status[rev_full_pos(NREG, i)] = rev_full[i];
      end
      status[slv_pend_pos(NREG)] = s_pend;
      status[mst_pend_pos(NREG)] = m_pend;
   end

   mbox_rdmux #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(ADDR_W), .RD_REG(RD_REG)) u_mrd (
      .clk(clk), .rst_n(rst_n), .regs(rev_regs), .status(status),
      .idx(m_addr), .rdata(m_rdata));

   mbox_rdmux #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(ADDR_W), .RD_REG(RD_REG)) u_srd (
      .clk(clk), .rst_n(rst_n), .regs(fwd_regs), .status(status),
      .idx(s_addr), .rdata(s_rdata));

   always_ff @(posedge clk) begin
      if (!rst_n) s_doorbell <= 1'b0;
      else        s_doorbell <= m_stat_wr;
   end

   assign m_irq = m_pend;
   assign s_irq = s_pend && s_irq_en;

   // R8
   stat_wr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_stat_wr |=> $stable(fwd_regs));
   // R11
   no_cs_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !m_cs |=> $stable(fwd_regs));
   // R11
   no_cs_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!m_cs && !s_wr) |=> $stable(rev_full));
   // R6
   slv_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s_irq_en |-> !s_irq);
endmodule

// File: tb/tb_mbox_port.sv
`timescale 1ns/1ps
module tb_mbox_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_cs = 0, m_wr = 0, m_rd = 0;
   logic [1:0] m_addr = 0;
   logic [7:0] m_wdata = 0;
   logic [7:0] m_rdata;
   logic       m_irq;
   logic       s_wr = 0, s_rd = 0;
   logic [1:0] s_addr = 0;
   logic [7:0] s_wdata = 0;
   logic [7:0] s_rdata;
   logic       s_irq_en = 0;
   logic       s_irq;
   logic       s_doorbell;

   int n_run = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   mbox_port dut (
      .clk(clk), .rst_n(rst_n),
      .m_cs(m_cs), .m_wr(m_wr), .m_rd(m_rd), .m_addr(m_addr),
      .m_wdata(m_wdata), .m_rdata(m_rdata), .m_irq(m_irq),
      .s_wr(s_wr), .s_rd(s_rd), .s_addr(s_addr), .s_wdata(s_wdata),
      .s_rdata(s_rdata), .s_irq_en(s_irq_en), .s_irq(s_irq),
      .s_doorbell(s_doorbell));

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic m_write(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      m_cs = 1; m_wr = 1; m_addr = a; m_wdata = d;
      @(negedge clk);
      m_cs = 0; m_wr = 0;
   endtask

   task automatic m_read(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      m_cs = 1; m_rd = 1; m_addr = a;
      #5 d = m_rdata;
      @(negedge clk);
      m_cs = 0; m_rd = 0;
   endtask

   task automatic s_write(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      s_wr = 1; s_addr = a; s_wdata = d;
      @(negedge clk);
      s_wr = 0;
   endtask

   task automatic s_read(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      s_rd = 1; s_addr = a;
      #5 d = s_rdata;
      @(negedge clk);
      s_rd = 0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      m_read(2'd3, v); check("R1 master status", v, 8'h00);
      s_read(2'd3, v); check("R1 slave status", v, 8'h00);
      check("R1 m_irq", {7'd0, m_irq}, 8'h00);
      check("R1 s_irq", {7'd0, s_irq}, 8'h00);
      check("R1 doorbell", {7'd0, s_doorbell}, 8'h00);
      s_read(2'd1, v); check("R1 fwd reg1", v, 8'h00);
   endtask

   task automatic t_fwd_path();
      logic [7:0] v;
      m_write(2'd1, 8'hA5);
      m_write(2'd2, 8'h3C);
      s_read(2'd3, v); check("R4 fwd flags", v, 8'h06);
      check("R7 no m_irq", {7'd0, m_irq}, 8'h00);
      s_read(2'd1, v); check("R2 fwd reg1", v, 8'hA5);
      m_read(2'd3, v); check("R4 flag1 cleared", v, 8'h04);
      s_read(2'd2, v); check("R2 fwd reg2", v, 8'h3C);
      s_read(2'd3, v); check("R4 all clear", v, 8'h00);
      s_read(2'd1, v); check("R2 reg1 kept", v, 8'hA5);
   endtask

   task automatic t_rev_path();
      logic [7:0] v;
      m_write(2'd1, 8'h11);
      s_write(2'd1, 8'h77);
      m_read(2'd3, v); check("R4 both flags", v, 8'h22);
      check("R7 no irq on reg1", {6'd0, m_irq, s_irq}, 8'h00);
      m_read(2'd1, v); check("R3 master reads rev reg", v, 8'h77);
      s_read(2'd3, v); check("R4 rev flag cleared", v, 8'h02);
      s_read(2'd1, v); check("R3 slave reads fwd reg", v, 8'h11);
      s_read(2'd3, v); check("R4 clear", v, 8'h00);
   endtask

   task automatic t_master_irq();
      logic [7:0] v;
      s_write(2'd0, 8'h5A);
      check("R5 m_irq set", {7'd0, m_irq}, 8'h01);
      m_read(2'd3, v); check("R5 status bit7", v, 8'h90);
      m_read(2'd0, v); check("R5 data", v, 8'h5A);
      check("R5 m_irq cleared", {7'd0, m_irq}, 8'h00);
      s_read(2'd3, v); check("R5 status clear", v, 8'h00);
   endtask

   task automatic t_slave_irq();
      logic [7:0] v;
      s_irq_en = 0;
      m_write(2'd0, 8'hC3);
      s_read(2'd3, v); check("R6 pending bit3", v, 8'h09);
      check("R6 gated off", {7'd0, s_irq}, 8'h00);
      s_irq_en = 1; #1;
      check("R6 enabled", {7'd0, s_irq}, 8'h01);
      s_read(2'd0, v); check("R6 data", v, 8'hC3);
      check("R6 s_irq cleared", {7'd0, s_irq}, 8'h00);
      m_read(2'd3, v); check("R6 status clear", v, 8'h00);
   endtask

   task automatic t_doorbell();
      logic [7:0] v;
      m_write(2'd2, 8'h44);
      m_write(2'd3, 8'hFF);
      check("R8 doorbell pulse", {7'd0, s_doorbell}, 8'h01);
      @(negedge clk);
      check("R8 doorbell one cycle", {7'd0, s_doorbell}, 8'h00);
      s_read(2'd3, v); check("R8 status untouched", v, 8'h04);
      s_read(2'd2, v); check("R8 reg2 kept", v, 8'h44);
      s_read(2'd0, v); check("R8 reg0 kept", v, 8'hC3);
      check("R8 no s_irq", {7'd0, s_irq}, 8'h00);
   endtask

   task automatic t_no_cs();
      logic [7:0] v;
      @(negedge clk);
      m_wr = 1; m_addr = 2'd1; m_wdata = 8'hEE;
      @(negedge clk);
      m_wr = 0;
      s_read(2'd3, v); check("R11 write ignored flags", v, 8'h00);
      s_read(2'd1, v); check("R11 write ignored data", v, 8'h11);
      s_write(2'd2, 8'h99);
      @(negedge clk);
      m_rd = 1; m_addr = 2'd2;
      @(negedge clk);
      m_rd = 0;
      s_read(2'd3, v); check("R11 read ignored", v, 8'h40);
      m_read(2'd2, v); check("R11 real read", v, 8'h99);
      s_read(2'd3, v); check("R11 cleared", v, 8'h00);
   endtask

   task automatic t_collide();
      logic [7:0] v;
      m_write(2'd1, 8'h21);
      @(negedge clk);
      m_cs = 1; m_wr = 1; m_addr = 2'd1; m_wdata = 8'h42;
      s_rd = 1; s_addr = 2'd1;
      #5 v = s_rdata;
      @(negedge clk);
      m_cs = 0; m_wr = 0; s_rd = 0;
      check("R9 old value read", v, 8'h21);
      s_read(2'd3, v); check("R9 flag stays", v, 8'h02);
      s_read(2'd1, v); check("R9 new data", v, 8'h42);
      s_irq_en = 1;
      m_write(2'd0, 8'h01);
      @(negedge clk);
      m_cs = 1; m_wr = 1; m_addr = 2'd0; m_wdata = 8'h02;
      s_rd = 1; s_addr = 2'd0;
      @(negedge clk);
      m_cs = 0; m_wr = 0; s_rd = 0;
      check("R9 irq stays", {7'd0, s_irq}, 8'h01);
      m_read(2'd3, v); check("R9 reg0 flag and pend", v, 8'h09);
      s_read(2'd0, v); check("R9 reg0 new data", v, 8'h02);
      m_read(2'd3, v); check("R9 clean", v, 8'h00);
   endtask

   task automatic t_status_read();
      logic [7:0] v;
      s_write(2'd0, 8'h66);
      m_read(2'd3, v); check("R10 first", v, 8'h90);
      s_read(2'd3, v); check("R10 slave", v, 8'h90);
      m_read(2'd3, v); check("R10 repeat", v, 8'h90);
      check("R10 m_irq held", {7'd0, m_irq}, 8'h01);
      m_read(2'd0, v); check("R10 data", v, 8'h66);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_run++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_fwd_path();
      t_rev_path();
      t_master_irq();
      t_slave_irq();
      t_doorbell();
      t_no_cs();
      t_collide();
      t_status_read();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule